// File: doc/BRIEF.md
# Decrementer Timer with Interrupt Request

This block is a down-counting timer register for a processor core. Software loads it through a plain register port and reads its current value at any time. While a count-enable tick is present the register counts down by one per tick. When the count passes through zero, the most significant bit changes from 0 to 1 and a request is latched.

The same latch is set when a software load flips the most significant bit from 0 to 1. Requests that arrive while one is already pending merge into a single pending request. The exception logic sees the request only while its external-interrupt enable is high. It clears the request with a one-cycle acknowledge when it takes the exception. Vectoring and saving of state belong to the surrounding exception logic and are not part of this block.

All pins are plain control and status signals. The load port has no handshake: a load is accepted in the cycle its strobe is high. There is no back-pressure anywhere.

Top module: `dec_timer`

## Requirements
- R1: On a rising clock edge with `tick_i` high and `wr_en_i` low, `count_o` becomes its previous value minus one, wrapping from 0 to all ones.
- R2: With `tick_i` and `wr_en_i` both low, `count_o` and the pending request keep their values. Reading `count_o` has no side effect.
- R3: With `wr_en_i` high, `count_o` becomes `wr_data_i` on the next edge, whether or not `tick_i` is high. A load takes priority over a decrement.
- R4: A decrement that takes bit 31 of the count from 0 to 1 (0x00000000 to 0xFFFFFFFF) sets the pending request in the same edge.
- R5: A load that takes bit 31 from 0 to 1 sets the pending request. A load or decrement that leaves bit 31 at 1, or clears it, does not set it.
- R6: Further transitions while a request is pending leave a single request, and one acknowledge clears it.
- R7: `irq_o` is high exactly when a request is pending and `ee_i` is 1. With `ee_i` at 0 the request stays pending and shows once `ee_i` returns to 1.
- R8: An `ack_i` pulse clears the pending request on that edge, unless R9 applies.
- R9: If `ack_i` and a new bit 31 transition from 0 to 1 fall on the same edge, the request stays pending.
- R10: After reset, `count_o` is all ones and no request is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one decrement per high cycle |
| wr_en_i | input | 1 | Software load strobe |
| wr_data_i | input | 32 | Value to load |
| ee_i | input | 1 | External-interrupt enable |
| ack_i | input | 1 | Exception taken, clears the request |
| count_o | output | 32 | Current count for software reads |
| irq_o | output | 1 | Masked exception request |

## Verification
The hardest case to reach is a countdown through zero. From the reset value that would take about four billion ticks. The bench instead loads small values such as 3 or 0 and ticks through the zero crossing. It also loads values that flip bit 31 directly, which exercises the load-triggered request.

The bench also steers the acknowledge so that it lands on the same edge as a new crossing. It does this by loading 0 one cycle ahead and then asserting tick and acknowledge together. A reference model, updated each clock, predicts both outputs with the enable held low and high.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int unsigned DEC_W = 32;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_DEC  = 2'd1,
    OP_LOAD = 2'd2
  } dec_op_e;
endpackage

// File: rtl/dec_counter.sv
module dec_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] count_o,
  output logic         msb_rise_o
);
  import dec_pkg::*;

  localparam logic [W-1:0] RST_VAL = {W{1'b1}};
  localparam logic [W-1:0] ONE     = W'(1);

  dec_op_e      op;
  logic [W-1:0] cnt_q, cnt_d;

  // load outranks decrement
  always_comb begin
    if (wr_en_i)     op = OP_LOAD;
    else if (tick_i) op = OP_DEC;
    else             op = OP_HOLD;
  end

  always_comb begin
    unique case (op)
      OP_LOAD: cnt_d = wr_data_i;
      OP_DEC:  cnt_d = cnt_q - ONE;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= RST_VAL;
    else         cnt_q <= cnt_d;
  end

  // sign bit going 0 -> 1 on this edge, from either source
  assign msb_rise_o = ~cnt_q[W-1] & cnt_d[W-1];
  assign count_o    = cnt_q;
endmodule

// File: rtl/dec_req_latch.sv
module dec_req_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  input  logic ee_i,
  output logic pend_o,
  output logic irq_o
);
  logic pend_q;

  // a new set on the same edge as ack wins, so nothing is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (set_i) pend_q <= 1'b1;
    else if (ack_i) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
  assign irq_o  = pend_q & ee_i;
endmodule

// File: rtl/dec_timer.sv
module dec_timer (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  input  logic        ee_i,
  input  logic        ack_i,
  output logic [31:0] count_o,
  output logic        irq_o
);
  localparam int unsigned W = dec_pkg::DEC_W;

  logic msb_rise;
  logic pend;

  dec_counter #(.W(W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .count_o   (count_o),
    .msb_rise_o(msb_rise)
  );

  dec_req_latch u_req (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (msb_rise),
    .ack_i (ack_i),
    .ee_i  (ee_i),
    .pend_o(pend),
    .irq_o (irq_o)
  );
endmodule

// File: rtl/dec_timer_chk.sv
module dec_timer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick_i,
  input logic        wr_en_i,
  input logic [31:0] wr_data_i,
  input logic        ee_i,
  input logic        ack_i,
  input logic [31:0] count_o,
  input logic        irq_o,
  input logic        pend
);
  p_dec_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_en_i) |=> (count_o == $past(count_o) - 32'd1));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_en_i) |=> $stable(count_o));

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (count_o == $past(wr_data_i)));

  p_rise_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(count_o[31]) |-> pend);

  p_merge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && !ack_i) |=> pend);

  p_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ee_i |-> !irq_o);

  p_ack_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !(!count_o[31] && (wr_en_i ? wr_data_i[31] : (tick_i && count_o == 32'd0))))
      |=> !pend);
endmodule

bind dec_timer dec_timer_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .wr_en_i  (wr_en_i),
  .wr_data_i(wr_data_i),
  .ee_i     (ee_i),
  .ack_i    (ack_i),
  .count_o  (count_o),
  .irq_o    (irq_o),
  .pend     (pend)
);

// File: tb/sim_dec_timer.sv
module sim_dec_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, wr = 1'b0, ee = 1'b0, ack = 1'b0;
  logic [31:0] wd = 32'd0;
  logic [31:0] cnt;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic [31:0] m_cnt;
  bit          m_pend;

  always #10 clk = ~clk;

  dec_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr),
    .wr_data_i(wd), .ee_i(ee), .ack_i(ack), .count_o(cnt), .irq_o(irq)
  );

  task automatic report_summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic compare(input string tag);
    bit exp_irq;
    exp_irq = m_pend & ee;
    compared++;
    if (cnt !== m_cnt || irq !== exp_irq) begin
      mismatched++;
      $display("FAIL %s: count=%h irq=%b expected count=%h irq=%b", tag, cnt, irq, m_cnt, exp_irq);
    end
  endtask

  // one clock with the current inputs; the model steps alongside
  task automatic cyc(input string tag);
    logic [31:0] nv;
    bit rise;
    if (wr)        nv = wd;
    else if (tick) nv = m_cnt - 32'd1;
    else           nv = m_cnt;
    rise = !m_cnt[31] && nv[31];
    @(posedge clk);
    m_cnt  = nv;
    m_pend = rise ? 1'b1 : (ack ? 1'b0 : m_pend);
    #2;
    compare(tag);
  endtask

  task automatic set_in(input bit t, input bit w, input logic [31:0] d, input bit e, input bit a);
    tick = t; wr = w; wd = d; ee = e; ack = a;
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not end, expected completion");
      report_summary();
      $finish;
    end
  end

  initial begin
    m_cnt = 32'hFFFF_FFFF;
    m_pend = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    compare("R10 reset state");
    rst_n = 1'b1;
    #1;
    // R10: no spurious request just after reset
    set_in(0, 0, 0, 1, 0); cyc("R10 idle after reset");
    // R1: ticking down from all ones
    set_in(1, 0, 0, 1, 0);
    for (int i = 0; i < 5; i++) cyc("R1 decrement");
    // R2: holding; reading has no effect
    set_in(0, 0, 0, 1, 0);
    for (int i = 0; i < 3; i++) cyc("R2 hold");
    // R3: load with and without a tick
    set_in(0, 1, 32'h0000_0003, 1, 0); cyc("R3 load");
    set_in(1, 1, 32'h0000_0002, 1, 0); cyc("R3 load beats tick");
    // R4: countdown through zero
    set_in(1, 0, 0, 1, 0);
    for (int i = 0; i < 4; i++) cyc("R4 pass through zero");
    // R6: another crossing while pending merges
    set_in(0, 1, 32'h0000_0000, 1, 0); cyc("R6 reload zero");
    set_in(1, 0, 0, 1, 0); cyc("R6 second crossing");
    set_in(0, 0, 0, 1, 1); cyc("R6 R8 single ack clears");
    set_in(0, 0, 0, 1, 0); cyc("R6 stays clear");
    // R5: load flipping bit 31 from 1 to 0, then 0 to 1
    set_in(0, 1, 32'h0000_0010, 1, 0); cyc("R5 load clears msb");
    set_in(0, 1, 32'h8000_0005, 1, 0); cyc("R5 load sets request");
    set_in(0, 0, 0, 1, 1); cyc("R8 ack");
    set_in(0, 1, 32'hC000_0000, 1, 0); cyc("R5 msb stays one no request");
    set_in(1, 0, 0, 1, 0); cyc("R5 decrement keeps msb one");
    // R7: masking keeps the request pending
    set_in(0, 1, 32'h0000_0001, 0, 0); cyc("R7 load low");
    set_in(1, 0, 0, 0, 0);
    for (int i = 0; i < 2; i++) cyc("R7 masked crossing");
    set_in(0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc("R7 masked pending");
    set_in(0, 0, 0, 1, 0); cyc("R7 unmasked shows");
    // R9: ack together with a new crossing
    set_in(0, 1, 32'h0000_0000, 1, 0); cyc("R9 prepare");
    set_in(1, 0, 0, 1, 1); cyc("R9 ack and crossing");
    set_in(0, 0, 0, 1, 0); cyc("R9 still pending");
    set_in(0, 0, 0, 1, 1); cyc("R9 R8 ack clears");
    set_in(0, 0, 0, 1, 0); cyc("R8 cleared");
    // wrap and long run
    set_in(1, 0, 0, 1, 0);
    for (int i = 0; i < 40; i++) cyc("R1 long run");
    finished = 1'b1;
    report_summary();
    $finish;
  end
endmodule